// File: doc/BRIEF.md
# Miss Request Issue Arbiter

This block decides which outstanding cache-miss entry goes out next as an acquire request toward the second-level cache. Two pools of entries feed it. The demand pool holds misses from instruction fetch and the prefetch pool holds misses from the prefetcher. Each pool presents one "waiting to issue" bit per entry together with that entry's line address. The bus side gives a ready signal that is high while the request channel is idle. An acquire is sent on a valid/ready handshake, and at most one goes out per cycle.

Demand entries have strict priority over prefetch entries, and the lowest-numbered waiting demand entry is chosen. Prefetch entries are served in the order they were allocated. An internal order queue records each allocation and is popped as entries leave. If an entry in the queue is no longer waiting, for example because it was flushed, it is discarded without being issued. When a request is sent, the block emits a one-hot write strobe into the chosen entry together with the victim way supplied by the replacement logic, so the entry records where its refill will land.

Top module: `miss_issue_arb`

## Requirements
- R1: After reset the order queue is empty, so no prefetch request is offered even if prefetch waiting bits are set, and `acq_valid` is 0 when no demand entry waits.
- R2: `acq_fire` is 1 only in a cycle where both `acq_valid` and `acq_ready` are 1. A cycle with `acq_ready` at 0 issues nothing and leaves the queue unchanged.
- R3: When any demand waiting bit is set, the offered request is a demand request (`acq_is_pf` = 0), whatever the prefetch state.
- R4: Among demand entries, `acq_idx` is the lowest index whose waiting bit is 1.
- R5: Prefetch entries are offered in the order of their allocation pushes (`pf_alloc_vld` with `pf_alloc_idx`). One queue slot is removed per issued prefetch.
- R6: When the entry at the head of the order queue has its waiting bit at 0, it is removed in that cycle without being offered (`acq_valid` = 0 if no demand waits). The next queued entry is offered in the following cycle.
- R7: `acq_addr` equals the line address of the entry named by `acq_idx` in the pool selected by `acq_is_pf`. Entry i occupies bits [i*ADDR_W +: ADDR_W] of `dmd_addr` or `pf_addr`.
- R8: On `acq_fire`, exactly one bit of `vic_we_dmd` or `vic_we_pf` is set, at the issued entry's index, and `vic_way` carries `victim_way`. With no fire, all strobes are 0.
- R9: A queued prefetch entry that loses to a demand entry, or that is not accepted because `acq_ready` is 0, stays at the head and is offered again.
- R10: The order queue holds PF_N indices. A push while it is full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dmd_wait | input | DMD_N | Demand entries waiting to issue |
| dmd_addr | input | DMD_N*ADDR_W | Packed demand entry line addresses |
| pf_wait | input | PF_N | Prefetch entries waiting to issue |
| pf_addr | input | PF_N*ADDR_W | Packed prefetch entry line addresses |
| pf_alloc_vld | input | 1 | Prefetch entry allocated this cycle |
| pf_alloc_idx | input | PF_IDX_W | Index of allocated prefetch entry |
| acq_ready | input | 1 | Request channel idle and accepting |
| victim_way | input | WAY_W | Victim way from replacement logic |
| acq_valid | output | 1 | A request is offered |
| acq_is_pf | output | 1 | Offered request comes from the prefetch pool |
| acq_idx | output | ID_W | Entry index of the offered request |
| acq_addr | output | ADDR_W | Line address of the offered request |
| acq_fire | output | 1 | Request accepted this cycle |
| vic_we_dmd | output | DMD_N | Victim-way write strobe per demand entry |
| vic_we_pf | output | PF_N | Victim-way write strobe per prefetch entry |
| vic_way | output | WAY_W | Victim way to record in the strobed entry |

## Verification
The in-line properties check four things on every cycle: a fire never happens without ready, a waiting demand entry never loses to a prefetch, a demand pick never skips a lower waiting index, and an issued prefetch entry is still waiting. They also check that the victim strobes are one-hot and tied to the fire, and that the queue never underflows or goes past its capacity. The bench scenarios cover the behaviour that depends on history. That includes arrival order across several pushes, stale heads being discarded, heads surviving preemption and back-pressure, a push being dropped when the queue is full, and the address each pick reports.

// File: rtl/miss_arb_pkg.sv
package miss_arb_pkg;
  localparam int unsigned DMD_N_DEF  = 4;
  localparam int unsigned PF_N_DEF   = 10;
  localparam int unsigned ADDR_W_DEF = 16;
  localparam int unsigned WAY_W_DEF  = 2;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/miss_low_pick.sv
module miss_low_pick #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/miss_pf_order_fifo.sv
module miss_pf_order_fifo #(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic             head_vld,
  output logic [IDX_W-1:0] head_idx
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [IDX_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_en, rd_en, full;

  assign full     = (cnt_q == FULL_CNT);
  assign head_vld = (cnt_q != '0);
  assign head_idx = slot_q[rd_q];
  assign wr_en    = push && !full;
  assign rd_en    = pop && head_vld;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (wr_en) wr_d = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (rd_en) rd_d = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    case ({wr_en, rd_en})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) slot_q[wr_q] <= push_idx;
  end

  // R5: never pop an empty queue
  p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> head_vld);
  // R10: occupancy stays within capacity
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  // R10: a push into a full queue without a pop leaves it full, not wrapped
  p_full_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> (cnt_q == FULL_CNT));
endmodule

// File: rtl/miss_issue_arb.sv
module miss_issue_arb
  import miss_arb_pkg::*;
#(
  parameter int unsigned DMD_N    = DMD_N_DEF,
  parameter int unsigned PF_N     = PF_N_DEF,
  parameter int unsigned ADDR_W   = ADDR_W_DEF,
  parameter int unsigned WAY_W    = WAY_W_DEF,
  parameter int unsigned DMD_IDX_W = idx_w(DMD_N),
  parameter int unsigned PF_IDX_W = idx_w(PF_N),
  parameter int unsigned ID_W     = (DMD_IDX_W > PF_IDX_W) ? DMD_IDX_W : PF_IDX_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DMD_N-1:0]        dmd_wait,
  input  logic [DMD_N*ADDR_W-1:0] dmd_addr,
  input  logic [PF_N-1:0]         pf_wait,
  input  logic [PF_N*ADDR_W-1:0]  pf_addr,
  input  logic                    pf_alloc_vld,
  input  logic [PF_IDX_W-1:0]     pf_alloc_idx,
  input  logic                    acq_ready,
  input  logic [WAY_W-1:0]        victim_way,
  output logic                    acq_valid,
  output logic                    acq_is_pf,
  output logic [ID_W-1:0]         acq_idx,
  output logic [ADDR_W-1:0]       acq_addr,
  output logic                    acq_fire,
  output logic [DMD_N-1:0]        vic_we_dmd,
  output logic [PF_N-1:0]         vic_we_pf,
  output logic [WAY_W-1:0]        vic_way
);
  logic [ADDR_W-1:0]    dmd_addr_a [DMD_N];
  logic [ADDR_W-1:0]    pf_addr_a  [PF_N];
  logic                 dmd_any;
  logic [DMD_IDX_W-1:0] dmd_sel;
  logic                 head_vld;
  logic [PF_IDX_W-1:0]  head_idx;
  logic                 head_live, head_stale, pf_pop;

  for (genvar g = 0; g < DMD_N; g++) begin : g_dmd_addr
    assign dmd_addr_a[g] = dmd_addr[g*ADDR_W +: ADDR_W];
  end
  for (genvar g = 0; g < PF_N; g++) begin : g_pf_addr
    assign pf_addr_a[g] = pf_addr[g*ADDR_W +: ADDR_W];
  end

  miss_low_pick #(.N(DMD_N), .IDX_W(DMD_IDX_W)) i_dmd_pick (
    .req   (dmd_wait),
    .found (dmd_any),
    .idx   (dmd_sel)
  );

  miss_pf_order_fifo #(.DEPTH(PF_N), .IDX_W(PF_IDX_W)) i_pf_order (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (pf_alloc_vld),
    .push_idx (pf_alloc_idx),
    .pop      (pf_pop),
    .head_vld (head_vld),
    .head_idx (head_idx)
  );

  assign head_live  = head_vld && pf_wait[head_idx];
  assign head_stale = head_vld && !pf_wait[head_idx];

  always_comb begin
    acq_valid = dmd_any || head_live;
    acq_is_pf = !dmd_any && head_live;
    acq_idx   = dmd_any ? ID_W'(dmd_sel) : ID_W'(head_idx);
    acq_addr  = dmd_any ? dmd_addr_a[dmd_sel] : pf_addr_a[head_idx];
    acq_fire  = acq_valid && acq_ready;
    pf_pop    = head_stale || (acq_fire && acq_is_pf);
    vic_we_dmd = '0;
    vic_we_pf  = '0;
    if (acq_fire && !acq_is_pf) vic_we_dmd[dmd_sel] = 1'b1;
    if (acq_fire && acq_is_pf)  vic_we_pf[head_idx] = 1'b1;
    vic_way = victim_way;
  end

  // R2: nothing is issued unless the channel is idle
  p_fire_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acq_fire |-> acq_ready);
  // R3: a waiting demand entry is never passed over for a prefetch
  p_dmd_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_valid && |dmd_wait) |-> !acq_is_pf);
  // R4: no lower demand index is waiting
  p_lowest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_valid && !acq_is_pf) |->
      ((dmd_wait & ((DMD_N'(1) << acq_idx) - DMD_N'(1))) == '0));
  // R6: an issued prefetch entry is still waiting
  p_live_pf_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_fire && acq_is_pf) |-> pf_wait[PF_IDX_W'(acq_idx)]);
  // R8: victim strobes are one-hot and only with a fire
  p_vic_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vic_we_pf, vic_we_dmd}) && (acq_fire == (|{vic_we_pf, vic_we_dmd})));
endmodule

// File: tb/test_miss_issue_arb.sv
module test_miss_issue_arb;
  localparam int DMD_N = 4, PF_N = 10, ADDR_W = 16, WAY_W = 2;

  logic                    clk, rst_n;
  logic [DMD_N-1:0]        dmd_wait;
  logic [DMD_N*ADDR_W-1:0] dmd_addr;
  logic [PF_N-1:0]         pf_wait;
  logic [PF_N*ADDR_W-1:0]  pf_addr;
  logic                    pf_alloc_vld;
  logic [3:0]              pf_alloc_idx;
  logic                    acq_ready;
  logic [WAY_W-1:0]        victim_way;
  logic                    acq_valid, acq_is_pf, acq_fire;
  logic [3:0]              acq_idx;
  logic [ADDR_W-1:0]       acq_addr;
  logic [DMD_N-1:0]        vic_we_dmd;
  logic [PF_N-1:0]         vic_we_pf;
  logic [WAY_W-1:0]        vic_way;

  int checks = 0, errors = 0;
  bit done = 0;

  miss_issue_arb i_miss_issue_arb (
    .clk(clk), .rst_n(rst_n), .dmd_wait(dmd_wait), .dmd_addr(dmd_addr),
    .pf_wait(pf_wait), .pf_addr(pf_addr), .pf_alloc_vld(pf_alloc_vld),
    .pf_alloc_idx(pf_alloc_idx), .acq_ready(acq_ready), .victim_way(victim_way),
    .acq_valid(acq_valid), .acq_is_pf(acq_is_pf), .acq_idx(acq_idx),
    .acq_addr(acq_addr), .acq_fire(acq_fire), .vic_we_dmd(vic_we_dmd),
    .vic_we_pf(vic_we_pf), .vic_way(vic_way)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {dmd_wait[3:0], ready, exp_valid, exp_idx[1:0]}
  localparam logic [7:0] VEC [8] = '{
    8'b0000_1_0_00, 8'b0001_1_1_00, 8'b0110_1_1_01, 8'b1000_1_1_11,
    8'b1100_0_1_10, 8'b1111_1_1_00, 8'b1010_1_1_01, 8'b0100_0_1_10
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dmd_a(input int i); return 16'h0100 + i; endfunction
  function automatic int pf_a(input int i);  return 16'h0200 + i; endfunction

  // expect a prefetch offer of entry e with given ready
  task automatic expect_pf(input int e, input bit rdy, input string req);
    chk({req, " valid"}, acq_valid, 1);
    chk({req, " is_pf"}, acq_is_pf, 1);
    chk({req, " idx"}, acq_idx, e);
    chk("R7 pf addr", acq_addr, pf_a(e));
    chk("R2 fire", acq_fire, rdy);
    chk("R8 pf strobe", vic_we_pf, rdy ? (1 << e) : 0);
  endtask

  task automatic push(input int e);
    @(negedge clk);
    pf_alloc_vld = 1'b1;
    pf_alloc_idx = 4'(e);
    @(negedge clk);
    pf_alloc_vld = 1'b0;
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    dmd_wait = '0; pf_wait = '0; pf_alloc_vld = 1'b0; pf_alloc_idx = '0;
    acq_ready = 1'b0; victim_way = 2'd2;
    for (int i = 0; i < DMD_N; i++) dmd_addr[i*ADDR_W +: ADDR_W] = 16'(dmd_a(i));
    for (int i = 0; i < PF_N; i++)  pf_addr[i*ADDR_W +: ADDR_W]  = 16'(pf_a(i));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset leaves queue empty even with prefetch waiting bits set
    pf_wait = '1; acq_ready = 1'b1;
    @(negedge clk); #5;
    chk("R1 valid after reset", acq_valid, 0);
    chk("R1 fire after reset", acq_fire, 0);
    pf_wait = '0;

    // demand vectors (R2, R4, R7, R8)
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      dmd_wait  = VEC[v][7:4];
      acq_ready = VEC[v][3];
      victim_way = 2'(v);
      #5;
      chk("R4 valid", acq_valid, VEC[v][2]);
      chk("R2 fire", acq_fire, VEC[v][2] & VEC[v][3]);
      if (VEC[v][2]) begin
        chk("R4 idx", acq_idx, VEC[v][1:0]);
        chk("R3 is_pf", acq_is_pf, 0);
        chk("R7 dmd addr", acq_addr, dmd_a(VEC[v][1:0]));
        chk("R8 dmd strobe", vic_we_dmd, VEC[v][3] ? (1 << VEC[v][1:0]) : 0);
        chk("R8 way", vic_way, v % 4);
      end
      chk("R8 no pf strobe", vic_we_pf, 0);
    end
    @(negedge clk);
    dmd_wait = '0; acq_ready = 1'b0;

    // R5: arrival order 7, 2, 5
    pf_wait[7] = 1'b1; pf_wait[2] = 1'b1; pf_wait[5] = 1'b1;
    push(7); push(2); push(5);
    acq_ready = 1'b1;
    #5 expect_pf(7, 1, "R5 first");
    @(negedge clk); pf_wait[7] = 1'b0;
    #5 expect_pf(2, 1, "R5 second");
    @(negedge clk); pf_wait[2] = 1'b0;
    #5 expect_pf(5, 1, "R5 third");
    @(negedge clk); pf_wait[5] = 1'b0;
    #5 chk("R5 drained", acq_valid, 0);

    // R3 / R9: demand preempts, head survives, back-pressure holds it
    pf_wait[4] = 1'b1;
    push(4);
    dmd_wait = 4'b0010;
    #5;
    chk("R3 demand wins idx", acq_idx, 1);
    chk("R3 demand wins is_pf", acq_is_pf, 0);
    chk("R8 no pf strobe on demand", vic_we_pf, 0);
    @(negedge clk);
    dmd_wait = '0; acq_ready = 1'b0;
    #5 expect_pf(4, 0, "R9 after preempt");
    @(negedge clk); acq_ready = 1'b1;
    #5 expect_pf(4, 1, "R9 after stall");
    @(negedge clk); pf_wait[4] = 1'b0;
    #5 chk("R9 drained", acq_valid, 0);

    // R6: stale head 3 skipped, then 8 issued
    pf_wait[8] = 1'b1;
    @(negedge clk);
    pf_alloc_vld = 1'b1; pf_alloc_idx = 4'd3;
    @(negedge clk);
    pf_alloc_idx = 4'd8;
    #5;
    chk("R6 stale not offered", acq_valid, 0);
    chk("R6 stale no strobe", vic_we_pf, 0);
    @(negedge clk);
    pf_alloc_vld = 1'b0;
    #5 expect_pf(8, 1, "R6 next after stale");
    @(negedge clk); pf_wait[8] = 1'b0;
    #5 chk("R6 drained", acq_valid, 0);

    // R10: fill all slots, extra push dropped
    acq_ready = 1'b0; pf_wait = '1;
    for (int i = 0; i < PF_N; i++) push(i);
    push(5);
    acq_ready = 1'b1;
    for (int i = 0; i < PF_N; i++) begin
      #5 expect_pf(i, 1, "R10 fill order");
      @(negedge clk); pf_wait[i] = 1'b0;
    end
    pf_wait[5] = 1'b1;
    #5 chk("R10 extra push dropped", acq_valid, 0);
    @(negedge clk);
    #5 chk("R10 still empty", acq_valid, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule